// File: doc/BRIEF.md
# Write-Through Data Cache Controller with Store Buffer

This block is a direct-mapped data cache that sits between a processor port and a word-wide memory. It holds 1 KB in 32 lines of 32 bytes. Loads that find their line return data in the same cycle they are presented. Loads that miss fetch the whole line from memory one word at a time, install it, and then complete. Stores never allocate a line. A store that hits updates the cached word under its byte mask. Every accepted store, hit or miss, is also placed into a four-entry store FIFO. The memory side drains that FIFO in arrival order, one entry per acknowledged memory write.

The processor holds `cpu_req` and its fields steady until `cpu_ready` is high at a clock edge. The controller has three states:

- `ST_LOOKUP` serves hits and accepts stores. On a load miss it takes the transition *miss* to `ST_DRAIN`.
- `ST_DRAIN` waits until the store FIFO is empty, then takes *drained* to `ST_FILL`. This guarantees that the fill reads memory only after every earlier store has landed.
- `ST_FILL` issues one read per word in ascending order. After the last acknowledged word it writes tag and valid and takes *filled* back to `ST_LOOKUP`. The held load then hits.

Top module: `wtc_cache_ctrl`

## Requirements
- R1: A byte address splits into tag = bits 31:10, line index = bits 9:5, word select = bits 4:2 and byte lane = bits 1:0; two addresses share a cached line exactly when bits 31:5 match.
- R2: After reset every line is invalid, so the first load of any address misses and reads memory, and no memory request is raised while idle.
- R3: A load that hits asserts `cpu_ready` in the cycle it is presented, with the cached word on `cpu_rdata`, and raises no memory read.
- R4: A load miss reads the 8 words of its line at addresses line base, base+4, …, base+28 in that order, one per `mem_rd_ack`. No `cpu_ready` is given while a fill is in progress. The load completes with the addressed word in the cycle after the last beat.
- R5: Each store accepted with `cpu_ready` enters the store FIFO with its address, data and byte mask. `mem_wr_req` is high exactly while the FIFO holds entries. Entries leave in acceptance order, one per `mem_wr_ack`.
- R6: A store that hits replaces, in the cached word, only the bytes whose `cpu_be` bit is set (bit n selects data bits 8n+7:8n); the other bytes keep their value.
- R7: A store that misses leaves the cache unchanged: the line resident at that index still hits, and a later load of the stored address misses.
- R8: When the FIFO holds 4 entries, a presented store gets no `cpu_ready` until an entry drains; stores into a non-full FIFO are accepted in the cycle presented.
- R9: A load miss raises `mem_rd_req` only when the store FIFO is empty, so the fill returns data that includes every earlier store.
- R10: A fill replaces the line at its index, so a previously resident line with a different tag misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte mask |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_rd_req | output | 1 | Fill word read request |
| mem_rd_addr | output | 32 | Byte address of the fill word |
| mem_rd_ack | input | 1 | Fill word delivered this cycle |
| mem_rd_data | input | 32 | Fill word data |
| mem_wr_req | output | 1 | Head FIFO entry awaits writing |
| mem_wr_addr | output | 32 | Byte address of head entry |
| mem_wr_data | output | 32 | Data of head entry |
| mem_wr_be | output | 4 | Byte mask of head entry |
| mem_wr_ack | input | 1 | Head entry written; pop it |

## Verification
The bench builds the controller with its default parameters: 32 lines of 32 bytes, 32-bit words and a 4-deep store FIFO. It attaches a 4 KB memory model whose write acknowledge latency can be set at run time. A short latency lets the vector table cover hits, byte-masked hit stores, write-around misses and conflict eviction, so that each ordering of drains and fills resolves quickly. A 40-cycle latency lets the FIFO fill up, which brings the full-buffer stall and the drain-before-fill rule into reach. The 4 KB model spans tags 0 to 3 at every index, enough for conflicting lines.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_FILL   = 2'd2
    } wtc_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/wtc_line_ram.sv
module wtc_line_ram #(
    parameter int WORD_W = 32,
    parameter int AW     = 8
) (
    input  logic                  clk,
    input  logic [AW-1:0]         rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [WORD_W/8-1:0]   wr_be
);
    localparam int NB    = WORD_W / 8;
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b])
                    mem_q[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/wtc_store_fifo.sv
module wtc_store_fifo #(
    parameter int W     = 68,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push)
            slot_q[wr_ptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (do_push && !do_pop)
                count_q <= count_q + 1'b1;
            else if (do_pop && !do_push)
                count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/wtc_cache_ctrl.sv
module wtc_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 32,
    parameter int WB_DEPTH   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    input  logic [WORD_W/8-1:0]   cpu_be,
    output logic                  cpu_ready,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_ack,
    input  logic [WORD_W-1:0]     mem_rd_data,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [WORD_W-1:0]     mem_wr_data,
    output logic [WORD_W/8-1:0]   mem_wr_be,
    input  logic                  mem_wr_ack
);
    localparam int BE_W   = WORD_W / 8;
    localparam int BSEL_W = $clog2(BE_W);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WPL    = LINE_BYTES / BE_W;
    localparam int WSEL_W = OFF_W - BSEL_W;
    localparam int RAM_AW = IDX_W + WSEL_W;
    localparam int ENT_W  = ADDR_W + WORD_W + BE_W;

    // Address fields
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;

    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[OFF_W +: IDX_W];
    assign req_wsel = cpu_addr[BSEL_W +: WSEL_W];

    // Control state
    wtc_state_e        state_q, state_d;
    logic [WSEL_W-1:0] beat_q;
    logic              last_beat;

    // Internal strobes
    logic              hit, line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              tag_we, ram_we, wb_push, wb_pop, wb_full, wb_empty;
    logic [RAM_AW-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic [BE_W-1:0]   ram_wbe;
    logic [ENT_W-1:0]  wb_head;

    assign hit       = line_valid && (line_tag == req_tag);
    assign last_beat = (beat_q == WSEL_W'(WPL - 1));

    wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (tag_we),
        .wr_idx   (req_idx),
        .wr_tag   (req_tag)
    );

    wtc_line_ram #(.WORD_W(WORD_W), .AW(RAM_AW)) u_data (
        .clk     (clk),
        .rd_addr ({req_idx, req_wsel}),
        .rd_data (cpu_rdata),
        .wr_en   (ram_we),
        .wr_addr (ram_waddr),
        .wr_data (ram_wdata),
        .wr_be   (ram_wbe)
    );

    wtc_store_fifo #(.W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wb_push),
        .din   ({cpu_addr, cpu_wdata, cpu_be}),
        .full  (wb_full),
        .pop   (wb_pop),
        .dout  (wb_head),
        .empty (wb_empty)
    );

    assign {mem_wr_addr, mem_wr_data, mem_wr_be} = wb_head;
    assign mem_wr_req  = !wb_empty;
    assign wb_pop      = mem_wr_ack && !wb_empty;
    assign mem_rd_addr = {req_tag, req_idx, beat_q, {BSEL_W{1'b0}}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOOKUP;
        else
            state_q <= state_d;
    end

    // Fill beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat_q <= '0;
        else if (state_q == ST_DRAIN)
            beat_q <= '0;
        else if (state_q == ST_FILL && mem_rd_ack)
            beat_q <= beat_q + 1'b1;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        mem_rd_req = 1'b0;
        wb_push    = 1'b0;
        tag_we     = 1'b0;
        ram_we     = 1'b0;
        ram_waddr  = {req_idx, req_wsel};
        ram_wdata  = cpu_wdata;
        ram_wbe    = cpu_be;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (!wb_full) begin
                            cpu_ready = 1'b1;
                            wb_push   = 1'b1;
                            ram_we    = hit;
                        end
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        state_d = ST_DRAIN;          // miss
                    end
                end
            end
            ST_DRAIN: begin
                if (wb_empty)
                    state_d = ST_FILL;               // drained
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                ram_waddr  = {req_idx, beat_q};
                ram_wdata  = mem_rd_data;
                ram_wbe    = '1;
                ram_we     = mem_rd_ack;
                if (mem_rd_ack && last_beat) begin
                    tag_we  = 1'b1;
                    state_d = ST_LOOKUP;             // filled
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

endmodule

// File: rtl/wtc_cache_checker.sv
module wtc_cache_checker #(
    parameter int WB_DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_ready,
    input logic mem_rd_req,
    input logic mem_wr_req,
    input logic mem_wr_ack
);
    localparam int OW = $clog2(WB_DEPTH + 1) + 1;

    logic [OW-1:0] occ_q;
    logic          acc_store, drained;

    assign acc_store = cpu_req && cpu_we && cpu_ready;
    assign drained   = mem_wr_req && mem_wr_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            occ_q <= '0;
        else
            occ_q <= occ_q + OW'(acc_store) - OW'(drained);
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(WB_DEPTH)); // R8
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && occ_q == OW'(WB_DEPTH)) |-> !cpu_ready); // R8
    AST_WR_REQ_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req == (occ_q != '0)); // R5
    AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (occ_q == '0)); // R9
    AST_NO_RESP_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !cpu_ready); // R4

endmodule

bind wtc_cache_ctrl wtc_cache_checker #(.WB_DEPTH(WB_DEPTH)) u_wtc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_ready  (cpu_ready),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_wr_ack (mem_wr_ack)
);

// File: tb/tb_wtc_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wtc_cache_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_rd_req, mem_rd_ack;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        mem_wr_req, mem_wr_ack;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;

    always #4 clk = ~clk;

    wtc_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
        .mem_wr_ack(mem_wr_ack)
    );

    // Memory model: 4 KB, one-cycle read ack, programmable write latency
    logic [31:0] mem [1024];
    int          wr_lat = 2;
    int          wcnt = 0;
    logic [31:0] rlog [256];
    logic [31:0] wlog_a [64];
    logic [31:0] wlog_d [64];
    logic [3:0]  wlog_b [64];
    int          rd_n = 0, wlog_n = 0, wn_at_first = 0;

    assign mem_rd_ack  = mem_rd_req;
    assign mem_rd_data = mem[mem_rd_addr[11:2]];
    assign mem_wr_ack  = mem_wr_req && (wcnt >= wr_lat);

    always @(posedge clk) begin
        if (mem_rd_req && mem_rd_ack) begin
            rlog[rd_n % 256] <= mem_rd_addr;
            rd_n <= rd_n + 1;
            if (mem_rd_addr[4:0] == 5'd0) wn_at_first <= wlog_n;
        end
        if (mem_wr_req && mem_wr_ack) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[mem_wr_addr[11:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
            wlog_a[wlog_n % 64] <= mem_wr_addr;
            wlog_d[wlog_n % 64] <= mem_wr_data;
            wlog_b[wlog_n % 64] <= mem_wr_be;
            wlog_n <= wlog_n + 1;
            wcnt <= 0;
        end else if (mem_wr_req) begin
            wcnt <= wcnt + 1;
        end else begin
            wcnt <= 0;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Processor access: returns data and number of stalled cycles
    task automatic op(input logic we, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [3:0]  beats;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, 32'h040, 32'h0,        4'h0, 32'h5A000040, 4'd8},
        '{1'b0, 32'h044, 32'h0,        4'h0, 32'h5A000044, 4'd0},
        '{1'b1, 32'h048, 32'h11223344, 4'h3, 32'h0,        4'd0},
        '{1'b0, 32'h048, 32'h0,        4'h0, 32'h5A003344, 4'd0},
        '{1'b1, 32'h440, 32'hDEADBEEF, 4'hF, 32'h0,        4'd0},
        '{1'b0, 32'h040, 32'h0,        4'h0, 32'h5A000040, 4'd0},
        '{1'b0, 32'h440, 32'h0,        4'h0, 32'hDEADBEEF, 4'd8},
        '{1'b0, 32'h040, 32'h0,        4'h0, 32'h5A000040, 4'd8},
        '{1'b0, 32'h048, 32'h0,        4'h0, 32'h5A003344, 4'd0}
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R2 cold load miss";
            1: return "R3 load hit";
            2: return "R5 store hit accepted";
            3: return "R6 masked store merge";
            4: return "R7 store miss accepted";
            5: return "R7 resident line still hits";
            6: return "R9 fill sees drained store";
            7: return "R10 conflict eviction";
            default: return "R5 store reached memory";
        endcase
    endfunction

    initial begin
        logic [31:0] rd;
        int          waits, rb;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A000000 | (i << 2);
        repeat (3) @(negedge clk);
        // Reset state (R2)
        chk("R2 reset cpu_ready", {31'b0, cpu_ready}, 32'd0);
        chk("R2 reset mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
        chk("R2 reset mem_wr_req", {31'b0, mem_wr_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            rb = rd_n;
            op(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].be, rd, waits);
            chk({vtag(i), " beats"}, 32'(rd_n - rb), 32'(VEC[i].beats));
            if (!VEC[i].we) chk({vtag(i), " data"}, rd, VEC[i].exp);
            if (VEC[i].beats == 0) chk({vtag(i), " no stall"}, 32'(waits), 32'd0);
        end

        // R5: drain order and contents
        chk("R5 write count", 32'(wlog_n), 32'd2);
        chk("R5 entry0 addr", wlog_a[0], 32'h048);
        chk("R5 entry0 data", wlog_d[0], 32'h11223344);
        chk("R5 entry0 mask", {28'b0, wlog_b[0]}, 32'h3);
        chk("R5 entry1 addr", wlog_a[1], 32'h440);

        // R1 and R4: fill order from line base, word select bits 4:2
        rb = rd_n;
        op(1'b0, 32'h1E4, 32'h0, 4'h0, rd, waits);
        chk("R1 offset word data", rd, 32'h5A0001E4);
        for (int k = 0; k < 8; k++)
            chk("R4 fill address order", rlog[(rb + k) % 256], 32'h1E0 + 32'(4 * k));
        op(1'b0, 32'h1FC, 32'h0, 4'h0, rd, waits);
        chk("R1 same line hit", 32'(rd_n - rb), 32'd8);
        chk("R1 last word data", rd, 32'h5A0001FC);

        // R8: full FIFO stalls a store
        wr_lat = 40;
        op(1'b1, 32'h800, 32'hCAFEF00D, 4'hF, rd, waits);
        chk("R8 store 1 immediate", 32'(waits), 32'd0);
        op(1'b1, 32'h900, 32'h00000900, 4'hF, rd, waits);
        op(1'b1, 32'h904, 32'h00000904, 4'hF, rd, waits);
        op(1'b1, 32'h908, 32'h00000908, 4'hF, rd, waits);
        chk("R8 store 4 immediate", 32'(waits), 32'd0);
        op(1'b1, 32'h90C, 32'h0000090C, 4'hF, rd, waits);
        checks++;
        if (waits < 20) begin
            errors++;
            $display("FAIL R8 fifth store stall actual=%0d expected>=20", waits);
        end

        // R9: load miss after queued stores
        rb = rd_n;
        op(1'b0, 32'h800, 32'h0, 4'h0, rd, waits);
        chk("R9 fill returns queued store", rd, 32'hCAFEF00D);
        chk("R9 drained before first beat", 32'(wn_at_first), 32'd7);
        chk("R5 order of 5th entry", wlog_a[6], 32'h90C);
        chk("R4 beats", 32'(rd_n - rb), 32'd8);

        // R2: reset invalidates resident lines
        wr_lat = 2;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 reset mid-run mem_wr_req", {31'b0, mem_wr_req}, 32'd0);
        rst_n = 1'b1;
        rb = rd_n;
        op(1'b0, 32'h804, 32'h0, 4'h0, rd, waits);
        chk("R2 miss after reset", 32'(rd_n - rb), 32'd8);
        chk("R2 data after reset", rd, 32'h5A000804);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule